// File: doc/BRIEF.md
# PHY Power Sequencing Controller

This block brings the analog part of an interface PHY up and down in a fixed order. It has two control outputs: an active-low power-down output (`pdb_out`, where 1 means powered) and a DLL enable. It also reads two status inputs from the PHY: one that says pad calibration has finished and one that says the DLL is ready. Either kind of request, power-on or power-off, first drives both control outputs low. This clears the PHY's calibration state machine.

A power-off request ends there and reports success. A power-on request then steps through three timed waits:

1. A quiet wait with both outputs low, after which power is applied.
2. A calibration wait, after which the calibration status is sampled. If calibration has finished, the DLL is enabled.
3. A DLL lock wait, after which the DLL status is sampled.

If either status is low at its sampling point, the sequence stops. It reports which stage failed and leaves both outputs as they were at that point. Each wait length is a parameter in clock cycles. It is computed from the clock frequency in MHz and a duration in nanoseconds, rounded up. The status inputs are asynchronous to the clock and pass through two-flop synchronizers.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `pdb_out`, `dll_en_out`, `busy` and `done` are 0 and `err_code` is 00.
- R2: A request accepted while idle makes `pdb_out` and `dll_en_out` 0 in the next cycle, whatever their earlier values.
- R3: An accepted power-off request gives `done`=1 with `err_code`=00 in the same cycle as the outputs go low, and `busy` stays 0.
- R4: After a power-on request is accepted, `busy` is 1 and `pdb_out` rises exactly QUIET_CYC cycles later. QUIET_CYC = ceil(3 µs × CLK_MHZ), which is 600 at 200 MHz.
- R5: The calibration status is sampled CAL_CYC cycles after `pdb_out` rises. CAL_CYC = ceil(5 µs × CLK_MHZ), which is 1000. If the status is 0, `done` pulses with `err_code`=01, `pdb_out` stays 1 and `dll_en_out` stays 0.
- R6: If the calibration status is 1 at its sampling point, `dll_en_out` rises in that same cycle, and `pdb_out` stays 1 from then on.
- R7: The DLL status is sampled DLL_CYC cycles after `dll_en_out` rises. DLL_CYC = ceil(11 µs × CLK_MHZ), which is 2200. The result is `done` with `err_code`=00 if the status is 1 and 10 if it is 0. Both outputs stay 1.
- R8: Each status input is synchronized by two flops. The decision at a sampling edge uses the input level as it stood two rising edges earlier. An input that rises after that edge is treated as 0.
- R9: `pwr_on_req` and `pwr_off_req` are ignored while `busy` is 1. The timing of the sequence in progress does not change. If both are asserted in the same idle cycle, power-on wins.
- R10: `done` is a one-cycle pulse and `busy` is 0 in that cycle. `err_code` is valid with `done` and holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_req | input | 1 | Start the power-on sequence (sampled while idle) |
| pwr_off_req | input | 1 | Power the PHY down (sampled while idle) |
| cal_done_in | input | 1 | Asynchronous pad-calibration-finished status from the PHY |
| dll_rdy_in | input | 1 | Asynchronous DLL-ready status from the PHY |
| pdb_out | output | 1 | Power-down bar to the PHY, 1 = powered |
| dll_en_out | output | 1 | DLL enable to the PHY |
| busy | output | 1 | A power-on sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 00 success, 01 calibration timeout, 10 DLL timeout |

## Verification
The hardest case to reach from the ports is the synchronizer boundary at the calibration sampling point. The status must rise at exactly the right edge, and one edge either way separates success from a calibration timeout. The bench counts edges from the rise of `pdb_out` and raises the status input at a chosen count. In one run it rises one edge too late for the two synchronizer stages, which must give error 01. In another it rises exactly in time, which must succeed. The same method places the ignored request pulses in the middle of a wait, and the bench then checks that every later edge count is unchanged.

// File: rtl/phy_pwr_seq_pkg.sv
// Package: shared types for the PHY power sequencing controller.
// Assumes: nothing beyond the 2-bit error encoding defined here.
package phy_pwr_seq_pkg;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_CAL  = 2'b01,
        ERR_DLL  = 2'b10
    } pwr_err_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUIET = 2'd1,
        ST_CAL   = 2'd2,
        ST_DLL   = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/phy_pwr_sync.sv
// Module: multi-stage level synchronizer for asynchronous status inputs.
// Assumes: inputs are slow levels; STAGES >= 2; resets to 0.
module phy_pwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous level in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Shift the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/phy_pwr_timer.sv
// Module: loadable down-counter for the sequencer's timed waits.
// Assumes: a load of N-1 makes `zero` true N cycles later; counting holds at 0.
module phy_pwr_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    // Load a new wait length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/phy_pwr_fsm.sv
// Module: sequencing state machine: quiet wait, power on, calibration check,
// DLL enable, DLL check. Assumes status inputs are already synchronized and
// that the timer reports zero after the loaded count has elapsed.
module phy_pwr_fsm
    import phy_pwr_seq_pkg::*;
#(
    parameter int CW        = 12,
    parameter int QUIET_CYC = 600,
    parameter int CAL_CYC   = 1000,
    parameter int DLL_CYC   = 2200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          on_req,
    input  logic          off_req,
    input  logic          cal_ok,
    input  logic          dll_ok,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          pdb,
    output logic          dll_en,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err
);

    localparam logic [CW-1:0] QUIET_LD = CW'(QUIET_CYC - 1);
    localparam logic [CW-1:0] CAL_LD   = CW'(CAL_CYC - 1);
    localparam logic [CW-1:0] DLL_LD   = CW'(DLL_CYC - 1);

    pwr_state_e state_q;

    // Timer load requests: one at the entry to each wait state.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = QUIET_LD;
        unique case (state_q)
            ST_IDLE:  if (on_req)              begin tmr_load = 1'b1; tmr_val = QUIET_LD; end
            ST_QUIET: if (tmr_zero)            begin tmr_load = 1'b1; tmr_val = CAL_LD;   end
            ST_CAL:   if (tmr_zero && cal_ok)  begin tmr_load = 1'b1; tmr_val = DLL_LD;   end
            default:  ;
        endcase
    end

    // State, control outputs, completion pulse and error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pdb     <= 1'b0;
            dll_en  <= 1'b0;
            done    <= 1'b0;
            err     <= ERR_NONE;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (on_req || off_req) begin
                        pdb    <= 1'b0;
                        dll_en <= 1'b0;
                        if (on_req) begin
                            state_q <= ST_QUIET;
                        end else begin
                            done <= 1'b1;
                            err  <= ERR_NONE;
                        end
                    end
                end
                ST_QUIET: begin
                    if (tmr_zero) begin
                        pdb     <= 1'b1;
                        state_q <= ST_CAL;
                    end
                end
                ST_CAL: begin
                    if (tmr_zero) begin
                        if (cal_ok) begin
                            dll_en  <= 1'b1;
                            state_q <= ST_DLL;
                        end else begin
                            done    <= 1'b1;
                            err     <= ERR_CAL;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_DLL: begin
                    if (tmr_zero) begin
                        done    <= 1'b1;
                        err     <= dll_ok ? ERR_NONE : ERR_DLL;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/phy_pwr_seq.sv
// Module: top of the PHY power sequencing controller.
// Assumes: CLK_MHZ is an integer clock frequency; wait durations are given
// in nanoseconds and rounded up to whole cycles.
module phy_pwr_seq #(
    parameter int CLK_MHZ    = 200,
    parameter int T_QUIET_NS = 3000,
    parameter int T_CAL_NS   = 5000,
    parameter int T_DLL_NS   = 11000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on_req,
    input  logic       pwr_off_req,
    input  logic       cal_done_in,
    input  logic       dll_rdy_in,
    output logic       pdb_out,
    output logic       dll_en_out,
    output logic       busy,
    output logic       done,
    output logic [1:0] err_code
);

    localparam int QUIET_CYC = (T_QUIET_NS * CLK_MHZ + 999) / 1000;
    localparam int CAL_CYC   = (T_CAL_NS   * CLK_MHZ + 999) / 1000;
    localparam int DLL_CYC   = (T_DLL_NS   * CLK_MHZ + 999) / 1000;
    localparam int MAX_CYC   = (QUIET_CYC > CAL_CYC)
                             ? ((QUIET_CYC > DLL_CYC) ? QUIET_CYC : DLL_CYC)
                             : ((CAL_CYC   > DLL_CYC) ? CAL_CYC   : DLL_CYC);
    localparam int CW        = $clog2(MAX_CYC + 1);

    logic [1:0]    status_sync;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    phy_pwr_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dll_rdy_in, cal_done_in}),
        .sync_out (status_sync)
    );

    phy_pwr_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    phy_pwr_fsm #(
        .CW        (CW),
        .QUIET_CYC (QUIET_CYC),
        .CAL_CYC   (CAL_CYC),
        .DLL_CYC   (DLL_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_req   (pwr_on_req),
        .off_req  (pwr_off_req),
        .cal_ok   (status_sync[0]),
        .dll_ok   (status_sync[1]),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .pdb      (pdb_out),
        .dll_en   (dll_en_out),
        .busy     (busy),
        .done     (done),
        .err      (err_code)
    );

endmodule

// File: rtl/phy_pwr_seq_chk.sv
// Module: protocol checker for phy_pwr_seq, attached with bind.
// Assumes: synchronous active-low reset; all checks are disabled during reset.
module phy_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on_req,
    input logic       pwr_off_req,
    input logic       pdb_out,
    input logic       dll_en_out,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code
);

    AST_REQ_DROPS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (pwr_on_req || pwr_off_req)) |=> (!pdb_out && !dll_en_out)); // R2

    AST_OFF_DONE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_off_req && !pwr_on_req) |=> (done && err_code == 2'b00 && !busy)); // R3

    AST_ON_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_on_req) |=> (busy && !done)); // R9

    AST_DLL_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_out |-> pdb_out); // R6

    AST_PDB_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdb_out) |-> (busy && !dll_en_out)); // R4

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!$fell(pdb_out) && !$fell(dll_en_out))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && err_code != 2'b11)); // R10

    AST_CAL_ERR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 2'b01) |-> (pdb_out && !dll_en_out)); // R5

    AST_DLL_ERR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 2'b10) |-> (pdb_out && dll_en_out)); // R7

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(err_code))); // R10

endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_on_req  (pwr_on_req),
    .pwr_off_req (pwr_off_req),
    .pdb_out     (pdb_out),
    .dll_en_out  (dll_en_out),
    .busy        (busy),
    .done        (done),
    .err_code    (err_code)
);

// File: tb/phy_pwr_seq_tb_top.sv
// Directed bench for phy_pwr_seq at 200 MHz; the PHY status pins are driven
// by the scenario tasks as a stand-in for the analog block.
module phy_pwr_seq_tb_top;

    localparam int MHZ   = 200;
    localparam int QUIET = 3 * MHZ;
    localparam int CALW  = 5 * MHZ;
    localparam int DLLW  = 11 * MHZ;
    localparam int LIMIT = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on_req = 1'b0;
    logic       pwr_off_req = 1'b0;
    logic       cal_done_in = 1'b0;
    logic       dll_rdy_in = 1'b0;
    logic       pdb_out, dll_en_out, busy, done;
    logic [1:0] err_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    phy_pwr_seq #(.CLK_MHZ(MHZ)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on_req  (pwr_on_req),
        .pwr_off_req (pwr_off_req),
        .cal_done_in (cal_done_in),
        .dll_rdy_in  (dll_rdy_in),
        .pdb_out     (pdb_out),
        .dll_en_out  (dll_en_out),
        .busy        (busy),
        .done        (done),
        .err_code    (err_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic do_off(input string tag);
        @(negedge clk) pwr_off_req = 1'b1;
        @(negedge clk) pwr_off_req = 1'b0;
        check(!pdb_out && !dll_en_out, {"R2 off outputs low ", tag}, {pdb_out, dll_en_out}, 0);
        check(done && err_code == 2'b00 && !busy, {"R3 off done ", tag},
              {done, busy, err_code}, 8);
        @(negedge clk);
        check(!done, {"R10 off pulse ", tag}, done, 0);
    endtask

    // Power-on scenario. cal_at/dll_at: negedge count at which the status
    // input rises (-1 = never). ign: pulse requests while busy. both: on+off together.
    task automatic do_on(input int cal_at, input int dll_at, input logic [1:0] exp_err,
                         input bit ign, input bit both, input string tag);
        int n;
        @(negedge clk);
        cal_done_in = 1'b0;
        dll_rdy_in  = 1'b0;
        pwr_on_req  = 1'b1;
        pwr_off_req = both;
        @(negedge clk);
        pwr_on_req  = 1'b0;
        pwr_off_req = 1'b0;
        check(!pdb_out && !dll_en_out, {"R2 on outputs low ", tag}, {pdb_out, dll_en_out}, 0);
        check(busy && !done, {"R4/R9 busy after on ", tag}, {busy, done}, 2);
        n = 0;
        while (!pdb_out && n < LIMIT) begin @(negedge clk); n++; end
        check(n == QUIET, {"R4 quiet length ", tag}, n, QUIET);
        n = 0;
        while (!dll_en_out && !done && n < LIMIT) begin
            if (ign && n == 10) pwr_off_req = 1'b1;
            if (ign && n == 11) pwr_off_req = 1'b0;
            if (ign && n == 20) pwr_on_req = 1'b1;
            if (ign && n == 21) pwr_on_req = 1'b0;
            if (n == cal_at) cal_done_in = 1'b1;
            @(negedge clk);
            n++;
        end
        check(n == CALW, {"R5/R6 cal sample point ", tag}, n, CALW);
        if (ign) check(pdb_out, {"R9 pdb kept while busy ", tag}, pdb_out, 1);
        if (exp_err == 2'b01) begin
            check(done && err_code == 2'b01, {"R5/R8 cal timeout ", tag}, err_code, 1);
            check(pdb_out && !dll_en_out, {"R5 outputs held ", tag}, {pdb_out, dll_en_out}, 2);
        end else begin
            check(dll_en_out && pdb_out && !done, {"R6 dll enabled ", tag},
                  {dll_en_out, done}, 2);
            n = 0;
            while (!done && n < LIMIT) begin
                if (n == dll_at) dll_rdy_in = 1'b1;
                @(negedge clk);
                n++;
            end
            check(n == DLLW, {"R7 dll sample point ", tag}, n, DLLW);
            check(err_code == exp_err, {"R7/R8 dll result ", tag}, err_code, exp_err);
            check(pdb_out && dll_en_out, {"R7 outputs held ", tag}, {pdb_out, dll_en_out}, 3);
        end
        check(!busy, {"R10 busy low at done ", tag}, busy, 0);
        @(negedge clk);
        check(!done && err_code == exp_err, {"R10 pulse and err held ", tag},
              {done, err_code}, exp_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!pdb_out && !dll_en_out && !busy && !done && err_code == 2'b00,
              "R1 reset state", {pdb_out, dll_en_out, busy, done, err_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_on(100, 100, 2'b00, 1'b0, 1'b0, "normal");
        do_off("after on");
        do_on(-1, -1, 2'b01, 1'b0, 1'b0, "no cal");
        do_off("after cal err");
        do_on(100, -1, 2'b10, 1'b0, 1'b0, "no dll");
        do_on(CALW - 2, -1, 2'b01, 1'b0, 1'b0, "cal late R8");
        do_on(CALW - 3, DLLW - 3, 2'b00, 1'b0, 1'b0, "both just in time R8");
        do_on(CALW - 3, DLLW - 2, 2'b10, 1'b0, 1'b0, "dll late R8");
        do_on(50, 50, 2'b00, 1'b1, 1'b0, "requests ignored R9");
        do_on(50, 50, 2'b00, 1'b0, 1'b1, "on wins R9");
        do_off("final");
        finish_run();
    end

endmodule